// File: doc/BRIEF.md
# Per-Core Shadow Row-Buffer Profiler

This block gathers per-core memory statistics over a profiling interval, free of the interference that other cores cause at the shared DRAM row buffers. Every memory access (one last-level cache miss) arrives tagged with the core that issued it, the target bank and the target row. For each core and bank pair the block keeps a private "shadow" open row: the row that would still sit in the row buffer if that core ran alone. An access whose row equals its own shadow row counts as a locality hit for that core. Accesses by other cores never disturb it. A per-core retire pulse counts instructions, so software can later form misses-per-thousand-instructions and a hit fraction across all banks. The block does no division and no grouping.

An interval-end strobe closes the current interval. It copies every live counter into a snapshot bank, clears the live counters and all shadow rows, and starts the next interval in the same cycle. Software selects a core on a read port and sees that core's snapshot values with no added latency. These values stay unchanged while the next interval counts.

Top module: `mcp_shadow_profiler`

## Requirements
- R1: After reset, every snapshot value (access, hit and instruction count) reads zero for every core.
- R2: Each valid access adds one to the live access (miss) counter of its tagged core and to no other core's counter.
- R3: An access is a hit when a shadow row is recorded for its core and bank and equals the access row. After every access, hit or miss, the shadow row for that core and bank becomes the access row. A hit adds one to that core's live hit counter.
- R4: Shadow rows are private to a core: accesses by other cores to the same bank neither create nor destroy a hit for that core.
- R5: Shadow rows are private to a bank: an access to one bank does not change the shadow row of another bank of the same core.
- R6: Bit c of the retire vector adds one to core c's live instruction counter, and several cores may retire in the same cycle.
- R7: Every live counter stops at its all-ones value and stays there instead of wrapping.
- R8: The interval-end strobe copies the live counter values held before that cycle into the snapshot. It zeroes the live counters and invalidates every shadow row. An access or retire in the strobe cycle is the first event of the new interval, and the first access after a clear is always a miss.
- R9: The snapshot changes only on the interval-end strobe. The read port returns the selected core's snapshot values in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | An access is present this cycle |
| acc_core_i | input | CORE_W | Issuing core of the access |
| acc_bank_i | input | BANK_W | Target bank of the access |
| acc_row_i | input | ROW_W | Target row of the access |
| retire_i | input | N_CORES | One instruction-retire pulse bit per core |
| ivl_end_i | input | 1 | Interval-end strobe |
| rd_core_i | input | CORE_W | Core whose snapshot is read |
| rd_acc_o | output | CNT_W | Snapshot access (miss) count of the selected core |
| rd_hit_o | output | CNT_W | Snapshot shadow-hit count of the selected core |
| rd_ins_o | output | CNT_W | Snapshot instruction count of the selected core |

## Verification
The bench interleaves two cores on one bank. A design that compared against a shared row instead of a private one would lose the repeat hit that follows the other core's access. It also returns to a bank after using a sibling bank, which catches a shadow table indexed by core alone. It places an access and a retire pulse in the strobe cycle itself, and repeats the last row of the previous interval right after a clear. A design that dropped strobe-cycle events, folded them into the old snapshot, or kept stale shadow rows would report wrong counts. A long same-row burst with a small counter width drives access, hit and instruction counts past their maximum, where a wrapping counter would read back small values. It also reads the snapshot mid-interval to catch any leak of live counts into it.

// File: rtl/mcp_prof_pkg.sv
package mcp_prof_pkg;

    // Select width for an index over n items; at least one bit.
    function automatic int unsigned sel_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/shadow_row_table.sv
module shadow_row_table #(
    parameter int unsigned N_CORES = 24,
    parameter int unsigned N_BANKS = 4,
    parameter int unsigned ROW_W   = 14,
    localparam int unsigned CORE_W = mcp_prof_pkg::sel_w(N_CORES),
    localparam int unsigned BANK_W = mcp_prof_pkg::sel_w(N_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              acc_valid_i,
    input  logic [CORE_W-1:0] acc_core_i,
    input  logic [BANK_W-1:0] acc_bank_i,
    input  logic [ROW_W-1:0]  acc_row_i,
    output logic              hit_o
);

    localparam int unsigned ENTRIES = N_CORES * N_BANKS;
    localparam int unsigned IDX_W   = mcp_prof_pkg::sel_w(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][ROW_W-1:0] row;
    } tbl_t;

    tbl_t             st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             take;

    assign in_range = (int'(acc_core_i) < int'(N_CORES)) && (int'(acc_bank_i) < int'(N_BANKS));
    assign idx      = IDX_W'(int'(acc_core_i) * int'(N_BANKS) + int'(acc_bank_i));
    assign take     = acc_valid_i && in_range;

    always_comb begin
        st_d  = st_q;
        hit_o = 1'b0;
        if (take) begin
            hit_o = st_q.vld[idx] && !clr_i && (st_q.row[idx] == acc_row_i);
        end
        if (clr_i) begin
            st_d.vld = '0;
        end
        if (take) begin
            st_d.vld[idx] = 1'b1;
            st_d.row[idx] = acc_row_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Back-to-back access to the same core, bank and row must hit (R3).
    assert_repeat_row_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr_i && $past(take) && ($past(idx) == idx) && ($past(acc_row_i) == acc_row_i))
        |-> hit_o);

    // The access in the clearing cycle is never a hit (R8).
    assert_clear_forces_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> !hit_o);

endmodule

// File: rtl/prof_counter_bank.sv
module prof_counter_bank #(
    parameter int unsigned N = 24,
    parameter int unsigned W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic [N-1:0]        inc_i,
    output logic [N-1:0][W-1:0] cnt_o
);

    localparam logic [W-1:0] MAX = '1;

    typedef struct packed {
        logic [N-1:0][W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        logic [W-1:0] nxt;
        cnt_d = cnt_q;
        for (int i = 0; i < int'(N); i++) begin
            nxt = clr_i ? '0 : cnt_q.cnt[i];
            if (inc_i[i] && (nxt != MAX)) begin
                nxt = nxt + 1'b1;
            end
            cnt_d.cnt[i] = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q.cnt;

    for (genvar g = 0; g < int'(N); g++) begin : g_chk
        // A full counter holds its value until cleared (R7).
        assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt_q.cnt[g] == MAX) && !clr_i) |=> (cnt_q.cnt[g] == MAX));
        // Without a clear a counter moves by at most one per cycle (R2).
        assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_i |=> ((cnt_q.cnt[g] == $past(cnt_q.cnt[g])) ||
                        (cnt_q.cnt[g] == $past(cnt_q.cnt[g]) + W'(1))));
        // After a clear only the strobe-cycle event can remain (R8).
        assert_clear_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> (cnt_q.cnt[g] <= W'(1)));
    end

endmodule

// File: rtl/prof_snapshot.sv
module prof_snapshot #(
    parameter int unsigned N = 24,
    parameter int unsigned W = 32,
    localparam int unsigned SEL_W = mcp_prof_pkg::sel_w(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_i,
    input  logic [N-1:0][W-1:0] acc_live_i,
    input  logic [N-1:0][W-1:0] hit_live_i,
    input  logic [N-1:0][W-1:0] ins_live_i,
    input  logic [SEL_W-1:0]    rd_sel_i,
    output logic [W-1:0]        rd_acc_o,
    output logic [W-1:0]        rd_hit_o,
    output logic [W-1:0]        rd_ins_o
);

    typedef struct packed {
        logic [N-1:0][W-1:0] acc;
        logic [N-1:0][W-1:0] hit;
        logic [N-1:0][W-1:0] ins;
    } snap_t;

    snap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_i) begin
            st_d.acc = acc_live_i;
            st_d.hit = hit_live_i;
            st_d.ins = ins_live_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_acc_o = '0;
        rd_hit_o = '0;
        rd_ins_o = '0;
        if (int'(rd_sel_i) < int'(N)) begin
            rd_acc_o = st_q.acc[rd_sel_i];
            rd_hit_o = st_q.hit[rd_sel_i];
            rd_ins_o = st_q.ins[rd_sel_i];
        end
    end

    // Snapshot is frozen between strobes (R9).
    assert_snapshot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(st_q));

    // Hits never outnumber accesses for any reported core (R3).
    assert_hit_not_above_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_o <= rd_acc_o);

endmodule

// File: rtl/mcp_shadow_profiler.sv
module mcp_shadow_profiler #(
    parameter int unsigned N_CORES = 24,
    parameter int unsigned N_BANKS = 4,
    parameter int unsigned ROW_W   = 14,
    parameter int unsigned CNT_W   = 32,
    localparam int unsigned CORE_W = mcp_prof_pkg::sel_w(N_CORES),
    localparam int unsigned BANK_W = mcp_prof_pkg::sel_w(N_BANKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid_i,
    input  logic [CORE_W-1:0]  acc_core_i,
    input  logic [BANK_W-1:0]  acc_bank_i,
    input  logic [ROW_W-1:0]   acc_row_i,
    input  logic [N_CORES-1:0] retire_i,
    input  logic               ivl_end_i,
    input  logic [CORE_W-1:0]  rd_core_i,
    output logic [CNT_W-1:0]   rd_acc_o,
    output logic [CNT_W-1:0]   rd_hit_o,
    output logic [CNT_W-1:0]   rd_ins_o
);

    logic                            shadow_hit;
    logic [N_CORES-1:0]              acc_inc;
    logic [N_CORES-1:0]              hit_inc;
    logic [N_CORES-1:0][CNT_W-1:0]   acc_live;
    logic [N_CORES-1:0][CNT_W-1:0]   hit_live;
    logic [N_CORES-1:0][CNT_W-1:0]   ins_live;
    logic                            acc_ok;

    assign acc_ok = acc_valid_i &&
                    (int'(acc_core_i) < int'(N_CORES)) &&
                    (int'(acc_bank_i) < int'(N_BANKS));

    always_comb begin
        acc_inc = '0;
        hit_inc = '0;
        for (int c = 0; c < int'(N_CORES); c++) begin
            if (acc_ok && (int'(acc_core_i) == c)) begin
                acc_inc[c] = 1'b1;
                hit_inc[c] = shadow_hit;
            end
        end
    end

    shadow_row_table #(
        .N_CORES (N_CORES),
        .N_BANKS (N_BANKS),
        .ROW_W   (ROW_W)
    ) shadow_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (ivl_end_i),
        .acc_valid_i (acc_valid_i),
        .acc_core_i  (acc_core_i),
        .acc_bank_i  (acc_bank_i),
        .acc_row_i   (acc_row_i),
        .hit_o       (shadow_hit)
    );

    prof_counter_bank #(.N(N_CORES), .W(CNT_W)) acc_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ivl_end_i),
        .inc_i (acc_inc),
        .cnt_o (acc_live)
    );

    prof_counter_bank #(.N(N_CORES), .W(CNT_W)) hit_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ivl_end_i),
        .inc_i (hit_inc),
        .cnt_o (hit_live)
    );

    prof_counter_bank #(.N(N_CORES), .W(CNT_W)) ins_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ivl_end_i),
        .inc_i (retire_i),
        .cnt_o (ins_live)
    );

    prof_snapshot #(.N(N_CORES), .W(CNT_W)) snap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (ivl_end_i),
        .acc_live_i (acc_live),
        .hit_live_i (hit_live),
        .ins_live_i (ins_live),
        .rd_sel_i   (rd_core_i),
        .rd_acc_o   (rd_acc_o),
        .rd_hit_o   (rd_hit_o),
        .rd_ins_o   (rd_ins_o)
    );

    // A hit is only credited alongside an access of the same core (R2).
    assert_hit_needs_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_hit |-> acc_ok);

endmodule

// File: tb/mcp_shadow_profiler_tb_top.sv
module mcp_shadow_profiler_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NC   = 4;
    localparam int NB   = 2;
    localparam int RW   = 4;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_core = '0;
    logic [0:0]    acc_bank = '0;
    logic [RW-1:0] acc_row = '0;
    logic [NC-1:0] retire = '0;
    logic          ivl_end = 1'b0;
    logic [1:0]    rd_core = '0;
    logic [CW-1:0] rd_acc, rd_hit, rd_ins;

    always #2.5 clk = ~clk;

    mcp_shadow_profiler #(
        .N_CORES (NC),
        .N_BANKS (NB),
        .ROW_W   (RW),
        .CNT_W   (CW)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid_i (acc_valid),
        .acc_core_i  (acc_core),
        .acc_bank_i  (acc_bank),
        .acc_row_i   (acc_row),
        .retire_i    (retire),
        .ivl_end_i   (ivl_end),
        .rd_core_i   (rd_core),
        .rd_acc_o    (rd_acc),
        .rd_hit_o    (rd_hit),
        .rd_ins_o    (rd_ins)
    );

    typedef struct {
        int    core;
        int    acc;
        int    hit;
        int    ins;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;

    // Reference model state
    int e_acc[NC], e_hit[NC], e_ins[NC];
    int l_acc[NC], l_hit[NC], l_ins[NC];
    bit sv[NC][NB];
    int srow[NC][NB];

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    // Driver: one cycle of stimulus, model updated from the requirements.
    task automatic drive(input bit av, input int c, input int b, input int r,
                         input logic [NC-1:0] ret, input bit iend);
        @(negedge clk);
        acc_valid = av;
        acc_core  = 2'(c);
        acc_bank  = 1'(b);
        acc_row   = RW'(r);
        retire    = ret;
        ivl_end   = iend;
        if (iend) begin
            for (int k = 0; k < NC; k++) begin
                l_acc[k] = e_acc[k]; l_hit[k] = e_hit[k]; l_ins[k] = e_ins[k];
                e_acc[k] = 0; e_hit[k] = 0; e_ins[k] = 0;
                for (int j = 0; j < NB; j++) sv[k][j] = 1'b0;
            end
        end
        if (av) begin
            bit hit;
            hit = sv[c][b] && (srow[c][b] == r);
            e_acc[c] = sat(e_acc[c]);
            if (hit) e_hit[c] = sat(e_hit[c]);
            sv[c][b] = 1'b1;
            srow[c][b] = r;
        end
        for (int k = 0; k < NC; k++) begin
            if (ret[k]) e_ins[k] = sat(e_ins[k]);
        end
    endtask

    task automatic idle();
        drive(1'b0, 0, 0, 0, '0, 1'b0);
    endtask

    // Push the last captured snapshot as expected items.
    task automatic push_snapshot(input string tag);
        for (int k = 0; k < NC; k++) begin
            exp_t it;
            it.core = k; it.acc = l_acc[k]; it.hit = l_hit[k]; it.ins = l_ins[k]; it.tag = tag;
            exp_q.push_back(it);
        end
    endtask

    // Monitor: reads each queued core and compares.
    task automatic monitor();
        while (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            @(negedge clk);
            rd_core = 2'(it.core);
            #1;
            check($sformatf("%s core%0d acc", it.tag, it.core), int'(rd_acc), it.acc);
            check($sformatf("%s core%0d hit", it.tag, it.core), int'(rd_hit), it.hit);
            check($sformatf("%s core%0d ins", it.tag, it.core), int'(rd_ins), it.ins);
        end
    endtask

    initial begin
        for (int k = 0; k < NC; k++) begin
            e_acc[k] = 0; e_hit[k] = 0; e_ins[k] = 0;
            l_acc[k] = 0; l_hit[k] = 0; l_ins[k] = 0;
            for (int j = 0; j < NB; j++) begin sv[k][j] = 1'b0; srow[k][j] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of the snapshot
        push_snapshot("R1 reset");
        monitor();

        // Interval A: R2 counting, R3 hit and shadow update, R4 core privacy, R5 bank privacy, R6 retire
        drive(1'b1, 0, 0, 3, 4'b0001, 1'b0);
        drive(1'b1, 0, 0, 3, 4'b0011, 1'b0);
        drive(1'b1, 0, 0, 5, 4'b0000, 1'b0);
        drive(1'b1, 0, 0, 5, 4'b0110, 1'b0);
        drive(1'b1, 1, 0, 3, 4'b0110, 1'b0);
        drive(1'b1, 0, 0, 5, 4'b0001, 1'b0);
        drive(1'b1, 0, 1, 5, 4'b0000, 1'b0);
        drive(1'b1, 1, 1, 3, 4'b1111, 1'b0);
        drive(1'b1, 1, 0, 3, 4'b0000, 1'b0);
        idle();
        drive(1'b0, 0, 0, 0, 4'b0010, 1'b0);
        // R8: strobe with an access and a retire in the same cycle
        drive(1'b1, 2, 0, 7, 4'b1000, 1'b1);
        idle();
        push_snapshot("R2/R3/R4/R5/R6/R8 interval A");
        monitor();

        // Interval B: R8 first access after clear misses, strobe-cycle event counted
        drive(1'b1, 0, 0, 5, 4'b0000, 1'b0);
        drive(1'b1, 2, 0, 7, 4'b0100, 1'b0);
        idle();
        // R9: snapshot unchanged mid-interval
        push_snapshot("R9 hold");
        monitor();
        // R7: long same-row burst saturates all three counters of core 3
        for (int n = 0; n < 22; n++) drive(1'b1, 3, 1, 9, 4'b1000, 1'b0);
        idle();
        drive(1'b0, 0, 0, 0, 4'b0000, 1'b1);
        idle();
        push_snapshot("R7/R8 interval B");
        monitor();

        // Interval C: empty interval reads zero after the clear (R8)
        repeat (3) idle();
        drive(1'b0, 0, 0, 0, 4'b0000, 1'b1);
        idle();
        push_snapshot("R8 interval C");
        monitor();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule